// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is a byte-wide SPI master driven through a small 32-bit register file. Software queues bytes by writing the transmit data word. A shift engine sends each queued byte MSB first in mode 0 while it captures the byte returned on the serial input, and pushes that byte into a receive queue. Software drains the receive queue by reading the receive data word. Both queues are first-in first-out buffers of `DEPTH` bytes.

A master-inhibit control bit lets software stage a batch of bytes and release them as one back-to-back burst. Two self-clearing control bits empty either queue. A keyed write restores the whole block to its reset state. The active-low select lines come straight from a select register. Single-cycle event pulses (byte done, receive full, receive overrun, transmit overflow) go to an external interrupt aggregator.

The shift engine is a four-state machine:
- `SH_IDLE` waits for a released, non-empty transmit queue (transition *launch*: pop a byte).
- `SH_LOW` holds SCLK low for `HALF_DIV` cycles (transition *rise*: sample the input).
- `SH_HIGH` holds SCLK high for `HALF_DIV` cycles. Its *fall* transition goes back to `SH_LOW` for the next bit, or to `SH_LAND` after bit 7.
- `SH_LAND` pushes the received byte (transition *retire*, back to `SH_IDLE`).

Top module: `spi_byte_master`

## Requirements
- R1: Registers sit at byte addresses 0x40 (soft reset), 0x60 (control), 0x64 (status), 0x68 (transmit data), 0x6C (receive data), 0x70 (select), 0x74 (transmit fill), 0x78 (receive fill). Read data is valid one clock after the request, and any other address reads as 0.
- R2: Writing 0x0000000A to 0x40 resets the block. Any other value written there changes nothing.
- R3: A control write with bit 5 set empties the transmit queue, and one with bit 6 set empties the receive queue. Neither bit is stored: both always read back as 0.
- R4: While control bit 8 is 1, written bytes wait in the transmit queue. Once it is 0, queued bytes are sent back to back, in the order they were written, until the queue is empty.
- R5: Status reads as {bit3 tx full, bit2 tx empty, bit1 rx full, bit0 rx empty}, with the other bits 0. Writes to status are ignored.
- R6: A byte received while the receive queue is full is discarded and pulses `evt_rx_overrun`. A push that fills the receive queue pulses `evt_rx_full`.
- R7: Every completed byte transfer pulses `evt_tx_empty` and `evt_rx_not_empty` once each.
- R8: Reading receive data while the receive queue is empty returns 0xDEADBEEF and leaves the queue unchanged.
- R9: The select register resets to all ones. `ss_n[i]` is low exactly while bit i of the register is 0.
- R10: After hardware reset, control reads 0, status reads 0x5, both fill counts read 0, and select reads 0xFFFFFFFF.
- R11: SCLK idles low. Each bit has `HALF_DIV` clocks low then `HALF_DIV` clocks high. MOSI is stable while SCLK is high, bits go out MSB first, and one byte takes 16*HALF_DIV+2 clocks.
- R12: The fill registers give the current queue levels. A transmit write while the transmit queue is full is dropped and pulses `evt_tx_overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| evt_tx_empty | output | 1 | Pulse per completed byte |
| evt_rx_not_empty | output | 1 | Pulse per completed byte |
| evt_rx_full | output | 1 | Pulse when a push fills the receive queue |
| evt_rx_overrun | output | 1 | Pulse when a received byte is discarded |
| evt_tx_overflow | output | 1 | Pulse when a transmit write is dropped |

## Verification
Read data is due one clock after the request edge. The bench drives requests on the falling edge and samples on the following falling edge, so each read sees the register value at that single rising edge.

A transmit write is received 16*HALF_DIV+2 clocks after its write edge. The bench reads the receive fill exactly one clock before that edge and expects 0, then reads it at that edge and expects 1. Multi-byte bursts wait a whole number of byte periods plus a short margin.

A serial-side scoreboard compares each byte seen on MOSI, at the rising SCLK edges, against a queue filled by the driver. Receive reads are compared with the bytes the slave model returned.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
    localparam logic [6:0] A_SOFTRST = 7'h40;
    localparam logic [6:0] A_CTRL    = 7'h60;
    localparam logic [6:0] A_STAT    = 7'h64;
    localparam logic [6:0] A_TXD     = 7'h68;
    localparam logic [6:0] A_RXD     = 7'h6C;
    localparam logic [6:0] A_SEL     = 7'h70;
    localparam logic [6:0] A_TXFILL  = 7'h74;
    localparam logic [6:0] A_RXFILL  = 7'h78;

    localparam int CB_TXCLR   = 5;
    localparam int CB_RXCLR   = 6;
    localparam int CB_INHIBIT = 8;

    localparam logic [31:0] RESET_KEY = 32'h0000_000A;
    localparam logic [31:0] EMPTY_RD  = 32'hDEAD_BEEF;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_LAND
    } shift_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R12: fill level never passes the depth
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R12: a push into a full queue with no pop leaves the level at depth
    p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_bm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       tx_pop,
    output logic [7:0] rx_byte,
    output logic       rx_push,
    output logic       busy,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    shift_state_t state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_sh, rx_sh;
    logic             sclk_q;
    logic             half_done;

    assign half_done = (div_q == DIV_W'(HALF_DIV - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (go)        state_d = SH_LOW;
            SH_LOW:  if (half_done) state_d = SH_HIGH;
            SH_HIGH: if (half_done) state_d = (bit_q == 3'd7) ? SH_LAND : SH_LOW;
            SH_LAND:                state_d = SH_IDLE;
            default:                state_d = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SH_IDLE;
        else if (clr) state_q <= SH_IDLE;
        else          state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk_q <= 1'b0;
        end else if (clr) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk_q <= 1'b0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    div_q <= '0;
                    bit_q <= '0;
                    if (go) tx_sh <= tx_byte;
                end
                SH_LOW: begin
                    div_q <= half_done ? '0 : div_q + 1'b1;
                    if (half_done) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[6:0], miso};
                    end
                end
                SH_HIGH: begin
                    div_q <= half_done ? '0 : div_q + 1'b1;
                    if (half_done) begin
                        sclk_q <= 1'b0;
                        if (bit_q != 3'd7) begin
                            tx_sh <= {tx_sh[6:0], 1'b0};
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                SH_LAND: div_q <= '0;
                default: div_q <= '0;
            endcase
        end
    end

    assign tx_pop  = (state_q == SH_IDLE) && go && !clr;
    assign rx_push = (state_q == SH_LAND) && !clr;
    assign rx_byte = rx_sh;
    assign busy    = (state_q != SH_IDLE);
    assign sclk    = sclk_q;
    assign mosi    = tx_sh[7];

    // R11: serial clock rests low whenever no byte is in flight
    p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    // R11: data out holds while the clock is high
    p_mosi_stable_r11: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int NUM_SS   = 1,
    parameter int DEPTH    = 256,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              evt_tx_empty,
    output logic              evt_rx_not_empty,
    output logic              evt_rx_full,
    output logic              evt_rx_overrun,
    output logic              evt_tx_overflow
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [31:0] CTRL_KEEP = ~((32'd1 << CB_TXCLR) | (32'd1 << CB_RXCLR));

    logic wr, rd, soft_rst;
    logic [31:0] ctrl_q, sel_q, rdata_q;
    logic tx_clr, rx_clr, tx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0] tx_head, rx_head, eng_rx_byte;
    logic eng_pop, eng_push, eng_busy, go;
    logic e_txe, e_rxne, e_rxf, e_rxo, e_txo;

    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign soft_rst = wr && (bus_addr == A_SOFTRST) && (bus_wdata == RESET_KEY);
    assign tx_clr   = soft_rst || (wr && bus_addr == A_CTRL && bus_wdata[CB_TXCLR]);
    assign rx_clr   = soft_rst || (wr && bus_addr == A_CTRL && bus_wdata[CB_RXCLR]);
    assign tx_push  = wr && (bus_addr == A_TXD) && !tx_full;
    assign rx_pop   = rd && (bus_addr == A_RXD) && !rx_empty;
    assign go       = !tx_empty && !ctrl_q[CB_INHIBIT];

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din(bus_wdata[7:0]),
        .pop(eng_pop), .dout(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_push), .din(eng_rx_byte),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .go(go),
        .tx_byte(tx_head), .tx_pop(eng_pop),
        .rx_byte(eng_rx_byte), .rx_push(eng_push), .busy(eng_busy),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // control and select registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '1;
        end else if (soft_rst) begin
            ctrl_q <= '0;
            sel_q  <= '1;
        end else if (wr) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (bus_addr == A_SEL)  sel_q  <= bus_wdata;
        end
    end

    // read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            unique case (bus_addr)
                A_CTRL:   rdata_q <= ctrl_q;
                A_STAT:   rdata_q <= {28'd0, tx_full, tx_empty, rx_full, rx_empty};
                A_RXD:    rdata_q <= rx_empty ? EMPTY_RD : {24'd0, rx_head};
                A_SEL:    rdata_q <= sel_q;
                A_TXFILL: rdata_q <= 32'(tx_cnt);
                A_RXFILL: rdata_q <= 32'(rx_cnt);
                default:  rdata_q <= '0;
            endcase
        end
    end

    // event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_txe  <= 1'b0;
            e_rxne <= 1'b0;
            e_rxf  <= 1'b0;
            e_rxo  <= 1'b0;
            e_txo  <= 1'b0;
        end else begin
            e_txe  <= eng_push;
            e_rxne <= eng_push;
            e_rxo  <= eng_push && rx_full && !rx_clr;
            e_rxf  <= eng_push && !rx_full && !rx_pop && !rx_clr
                      && (rx_cnt == CW'(DEPTH - 1));
            e_txo  <= wr && (bus_addr == A_TXD) && tx_full && !tx_clr;
        end
    end

    assign bus_rdata        = rdata_q;
    assign ss_n             = sel_q[NUM_SS-1:0];
    assign evt_tx_empty     = e_txe;
    assign evt_rx_not_empty = e_rxne;
    assign evt_rx_full      = e_rxf;
    assign evt_rx_overrun   = e_rxo;
    assign evt_tx_overflow  = e_txo;

    // R2: a wrong key leaves the select lines untouched
    p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_SOFTRST && bus_wdata != RESET_KEY) |=> $stable(ss_n));
    // R8: an empty receive read answers with the poison word
    p_poison_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == A_RXD && rx_empty) |=> (bus_rdata == EMPTY_RD));
    // R8: an empty receive read does not move the fill level
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == A_RXD && rx_empty && !eng_push && !rx_clr)
        |=> (rx_cnt == '0));
    // R4: no byte launches while inhibit is held
    p_inhibit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_INHIBIT] && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb_top;
    localparam int CLK_P  = 10;
    localparam int NSS    = 2;
    localparam int DEP    = 8;
    localparam int HD     = 2;
    localparam int BYTE_T = 16 * HD + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic sclk, mosi, miso;
    logic [NSS-1:0] ss_n;
    logic e_txe, e_rxne, e_rxf, e_rxo, e_txo;

    int n_chk = 0, n_bad = 0;
    int c_txe = 0, c_rxne = 0, c_rxf = 0, c_rxo = 0, c_txo = 0;

    always #(CLK_P / 2) clk = ~clk;

    spi_byte_master #(.NUM_SS(NSS), .DEPTH(DEP), .HALF_DIV(HD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .evt_tx_empty(e_txe), .evt_rx_not_empty(e_rxne), .evt_rx_full(e_rxf),
        .evt_rx_overrun(e_rxo), .evt_tx_overflow(e_txo)
    );

    always @(posedge clk) begin
        if (e_txe)  c_txe++;
        if (e_rxne) c_rxne++;
        if (e_rxf)  c_rxf++;
        if (e_rxo)  c_rxo++;
        if (e_txo)  c_txo++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [7:0] mosi_exp[$];
    logic [7:0] rx_exp[$];
    int   xfers = 0;
    int   bitn = 0;
    logic [7:0] cap = '0;
    time  rise_t[$];

    function automatic logic [7:0] resp_of(input int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    always_comb miso = resp_of(xfers)[3'(7 - bitn)];

    // monitor: slave side
    always @(posedge sclk) begin
        rise_t.push_back($time);
        cap = {cap[6:0], mosi};
        if (bitn == 7) begin
            rx_exp.push_back(resp_of(xfers));
            n_chk++;
            if (mosi_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R4: actual=%h expected=<none>", cap);
            end else begin
                logic [7:0] e;
                e = mosi_exp.pop_front();
                if (cap !== e) begin
                    n_bad++;
                    $display("FAIL R11: actual=%h expected=%h", cap, e);
                end
            end
            xfers = xfers + 1;
            bitn = 0;
        end else begin
            bitn = bitn + 1;
        end
    end

    // ---------------- driver ----------------
    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send(input logic [7:0] b);
        mosi_exp.push_back(b);
        wr_reg(7'h68, {24'd0, b});
    endtask

    task automatic expect_rx(input string req);
        logic [31:0] v;
        logic [7:0] e;
        e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'h00;
        rd_reg(7'h6C, v);
        check(req, v, {24'd0, e});
    endtask

    task automatic wait_bytes(input int n);
        repeat (n * BYTE_T + 4) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int x0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd_reg(7'h64, v); check("R10 status", v, 32'h5);
        rd_reg(7'h60, v); check("R10 ctrl", v, 32'h0);
        rd_reg(7'h70, v); check("R10 select", v, 32'hFFFF_FFFF);
        rd_reg(7'h74, v); check("R10 txfill", v, 32'h0);
        check("R9 reset lines", 32'(ss_n), 32'h3);
        rd_reg(7'h44, v); check("R1 unmapped", v, 32'h0);

        // R9 select lines
        wr_reg(7'h70, 32'hFFFF_FFFE);
        check("R9 line0 low", 32'(ss_n), 32'h2);

        // single byte: exact timing R11, events R7
        send(8'hA5);
        repeat (BYTE_T - 1) @(negedge clk);
        rd_reg(7'h78, v); check("R11 not yet landed", v, 32'h0);
        rd_reg(7'h78, v); check("R11 landed on time", v, 32'h1);
        check("R7 tx-empty pulses", 32'(c_txe), 32'd1);
        check("R7 rx-not-empty pulses", 32'(c_rxne), 32'd1);
        check("R11 sclk period", 32'(rise_t[1] - rise_t[0]), 32'(2 * HD * CLK_P));
        check("R11 sclk idle low", 32'(sclk), 32'h0);
        expect_rx("R1 rx data");

        // R8 empty read
        rd_reg(7'h6C, v); check("R8 poison", v, 32'hDEAD_BEEF);
        rd_reg(7'h78, v); check("R8 fill unchanged", v, 32'h0);

        // R4 inhibit then release
        wr_reg(7'h60, 32'h100);
        x0 = xfers;
        send(8'h01); send(8'h80); send(8'h5A);
        wait_bytes(3);
        rd_reg(7'h74, v); check("R4 held in queue", v, 32'h3);
        check("R4 nothing sent", 32'(xfers - x0), 32'h0);
        rd_reg(7'h60, v); check("R4 ctrl readback", v, 32'h100);
        wr_reg(7'h60, 32'h0);
        wait_bytes(3);
        rd_reg(7'h78, v); check("R12 rx fill", v, 32'h3);
        expect_rx("R4 order 0"); expect_rx("R4 order 1"); expect_rx("R4 order 2");

        // R3 transmit clear
        wr_reg(7'h60, 32'h100);
        wr_reg(7'h68, 32'h11); wr_reg(7'h68, 32'h22);
        wr_reg(7'h60, 32'h120);
        rd_reg(7'h74, v); check("R3 tx cleared", v, 32'h0);
        rd_reg(7'h60, v); check("R3 bits read zero", v, 32'h100);
        send(8'hC3);
        wr_reg(7'h60, 32'h0);
        wait_bytes(1);
        rd_reg(7'h78, v); check("R3 rx before clear", v, 32'h1);
        wr_reg(7'h60, 32'h40);
        rx_exp.delete();
        rd_reg(7'h78, v); check("R3 rx cleared", v, 32'h0);
        rd_reg(7'h60, v); check("R3 rx bit reads zero", v, 32'h0);

        // R5 status write ignored
        wr_reg(7'h64, 32'hF);
        rd_reg(7'h64, v); check("R5 status write ignored", v, 32'h5);

        // R12 / R6 full, overflow, overrun
        wr_reg(7'h60, 32'h100);
        for (int i = 0; i < DEP; i++) send(8'(8'h40 + i));
        rd_reg(7'h64, v); check("R5 tx full", v, 32'h9);
        wr_reg(7'h68, 32'h77);
        @(negedge clk);
        check("R12 overflow pulse", 32'(c_txo), 32'd1);
        rd_reg(7'h74, v); check("R12 tx fill at depth", v, 32'(DEP));
        wr_reg(7'h60, 32'h0);
        wait_bytes(DEP);
        rd_reg(7'h64, v); check("R5 rx full", v, 32'h6);
        check("R6 full pulse", 32'(c_rxf), 32'd1);
        send(8'hEE);
        wait_bytes(1);
        check("R6 overrun pulse", 32'(c_rxo), 32'd1);
        void'(rx_exp.pop_back());
        rd_reg(7'h78, v); check("R6 fill kept", v, 32'(DEP));
        for (int i = 0; i < DEP; i++) expect_rx("R6 kept data");
        rd_reg(7'h64, v); check("R5 both empty", v, 32'h5);

        // R2 keyed reset
        wr_reg(7'h70, 32'h0);
        wr_reg(7'h60, 32'h100);
        wr_reg(7'h68, 32'h99);
        wr_reg(7'h40, 32'h5);
        check("R2 bad key lines", 32'(ss_n), 32'h0);
        rd_reg(7'h74, v); check("R2 bad key fill", v, 32'h1);
        wr_reg(7'h40, 32'hA);
        check("R2 key lines", 32'(ss_n), 32'h3);
        rd_reg(7'h60, v); check("R2 ctrl cleared", v, 32'h0);
        rd_reg(7'h74, v); check("R2 tx emptied", v, 32'h0);
        wait_bytes(1);
        check("R4 all bytes seen", 32'(mosi_exp.size()), 32'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule